// File: doc/BRIEF.md
# Loop Master Frame Supervisor

This block watches the frame timing at the line-card end of a two-wire burst loop. It runs on a fast system clock. Its inputs are an 8 kHz frame reference, a one-cycle strobe from the demodulator for each burst received without error, and three control pins: power enable, an active-low loopback request and a signal enable. The frame reference and the control pins are asynchronous. Each one passes through a two-flop synchroniser, and the frame reference is edge detected in the system clock domain.

The block drives five things: a valid-data flag, an output enable for the valid-data and received D-channel pads, the latched power and loopback levels, a one-cycle strobe that starts each outgoing burst, and a time-out flag. A saturating counter of missed frames sets the time-out flag. The valid-data flag follows frame edges while the block is powered up. While it is powered down, the flag follows the demodulator instead. While the signal enable is low, the latched controls are frozen and the status pads are released.

Top module: `loop_supervisor`

## Requirements
- R1: While reset is high and in the cycle after it, `timeout` is 1 and `valid_data`, `tx_start`, `status_oe`, `pwr_latched` and `loop_sel` are 0. `lpbk_n_latched` is 1.
- R2: While `pwr_latched` is 1, `valid_data` changes only at a synchronised rising edge of `frame_ref_in`. At that edge `valid_data` becomes 1 unless the same edge puts the block into time-out.
- R3: While `pwr_latched` is 0, a `burst_ok` pulse sets `valid_data` to 1 in the next cycle. The flag then holds until a frame edge puts the block into time-out.
- R4: The miss counter is cleared by `burst_ok` and counts up by one at each frame edge that has no burst. It saturates at 3. `timeout` is set at the third frame edge after the last burst and stays set for any longer outage.
- R5: A burst received during time-out leaves `timeout` at 1 until the next frame edge. That edge clears it.
- R6: At the frame edge that sets `timeout`, `valid_data` becomes 0.
- R7: While powered up, every frame edge produces exactly one single-cycle `tx_start` pulse. While powered down, no pulse is produced.
- R8: While `sig_en_in` is low, `pwr_latched` and `lpbk_n_latched` keep the levels they held when it fell. Changes on `pwr_up_in` and `lpbk_n_in` have no effect until `sig_en_in` rises again.
- R9: `status_oe` follows the synchronised `sig_en_in`. A value of 0 means the valid-data and D-channel pads are high-impedance.
- R10: `loop_sel` is 1 only while the block is powered up and the latched loopback level is 0 (loopback is active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_ref_in | input | 1 | Asynchronous 8 kHz frame reference |
| burst_ok | input | 1 | One-cycle strobe: burst demodulated without error |
| pwr_up_in | input | 1 | Power enable, 1 = powered up (asynchronous) |
| lpbk_n_in | input | 1 | Loopback request, active low (asynchronous) |
| sig_en_in | input | 1 | Signal enable; low freezes controls and releases status pads |
| valid_data | output | 1 | Valid-data flag |
| status_oe | output | 1 | Output enable for the valid-data and D-channel pads |
| pwr_latched | output | 1 | Latched power level |
| lpbk_n_latched | output | 1 | Latched loopback level (active low) |
| tx_start | output | 1 | Single-cycle strobe that starts an outgoing burst |
| loop_sel | output | 1 | Routes the modulator to the demodulator and idles the line |
| timeout | output | 1 | Time-out state: no burst for three frame edges |

## Verification
The hardest state to reach is a powered-down block in time-out that receives a burst. In that case `valid_data` must rise at once while `timeout` stays set until the next frame edge. A second hard case is a control change made while the signal enable is low, which must not reach the latched outputs. The stimulus reaches both with directed sequences: power down, let three frame edges pass, then strobe a burst; and drop the signal enable, toggle power and loopback, then raise it. A seeded random mix of frame edges, bursts, power toggles, loopback toggles and signal-enable windows then runs against a bench model that tracks the miss count at the level of events.

// File: rtl/loopsup_pkg.sv
package loopsup_pkg;
  // asynchronous control inputs carried through one synchroniser
  typedef struct packed {
    logic frame;
    logic sig_en;
    logic pwr;
    logic lpbk_n;
  } ctl_in_t;
endpackage

// File: rtl/loopsup_sync.sv
module loopsup_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/loopsup_ctrl.sv
module loopsup_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic se_s,
  input  logic pwr_s,
  input  logic lpbk_n_s,
  output logic pwr_q,
  output logic lpbk_n_q,
  output logic oe_q,
  output logic loop_sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q      <= 1'b0;
      lpbk_n_q   <= 1'b1;
      oe_q       <= 1'b0;
      loop_sel_q <= 1'b0;
    end else begin
      if (se_s) begin
        pwr_q    <= pwr_s;
        lpbk_n_q <= lpbk_n_s;
      end
      oe_q       <= se_s;
      loop_sel_q <= pwr_q & ~lpbk_n_q;
    end
  end

  // R8: two cycles of released pads mean the controls were frozen
  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!oe_q && !$past(oe_q)) |-> ($stable(pwr_q) && $stable(lpbk_n_q)));

  // R10: loopback is selected only after a powered-up cycle
  assert_loop_needs_power_R10: assert property (@(posedge clk) disable iff (rst)
    loop_sel_q |-> $past(pwr_q));
endmodule

// File: rtl/loopsup_frame.sv
module loopsup_frame #(
  parameter int MISS_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_lvl,
  input  logic burst_ok,
  input  logic pwr_up,
  output logic valid_q,
  output logic timeout_q,
  output logic tx_start_q
);
  localparam int CW = $clog2(MISS_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(MISS_LIMIT);

  logic          frame_d;
  logic          frame_rise;
  logic [CW-1:0] miss_cnt;
  logic [CW-1:0] miss_next;

  assign frame_rise = frame_lvl & ~frame_d;

  always_comb begin
    miss_next = miss_cnt;
    if (burst_ok)
      miss_next = '0;
    else if (frame_rise && miss_cnt != LIM)
      miss_next = miss_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_d    <= 1'b0;
      miss_cnt   <= LIM;
      timeout_q  <= 1'b1;
      valid_q    <= 1'b0;
      tx_start_q <= 1'b0;
    end else begin
      frame_d    <= frame_lvl;
      miss_cnt   <= miss_next;
      tx_start_q <= frame_rise & pwr_up;
      if (frame_rise) begin
        timeout_q <= (miss_next == LIM);
        valid_q   <= (miss_next != LIM);
      end else if (!pwr_up && burst_ok) begin
        valid_q   <= 1'b1;
      end
    end
  end

  // R2: powered up, valid-data holds between frame edges
  assert_vd_frame_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    (pwr_up && !frame_rise) |=> $stable(valid_q));

  // R3: powered down, a burst raises valid-data next cycle
  assert_down_burst_R3: assert property (@(posedge clk) disable iff (rst)
    (!pwr_up && burst_ok) |=> valid_q);

  // R5: time-out is left only at a frame edge
  assert_timeout_release_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(timeout_q) |-> $past(frame_rise));

  // R6: entering time-out drops valid-data
  assert_enter_timeout_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_q) |-> !valid_q);

  // R7: the burst start strobe lasts one cycle
  assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    tx_start_q |=> !tx_start_q);
endmodule

// File: rtl/loop_supervisor.sv
module loop_supervisor #(
  parameter int SYNC_STAGES = 2,
  parameter int MISS_LIMIT  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_ref_in,
  input  logic burst_ok,
  input  logic pwr_up_in,
  input  logic lpbk_n_in,
  input  logic sig_en_in,
  output logic valid_data,
  output logic status_oe,
  output logic pwr_latched,
  output logic lpbk_n_latched,
  output logic tx_start,
  output logic loop_sel,
  output logic timeout
);
  import loopsup_pkg::*;

  ctl_in_t raw_in;
  ctl_in_t syn_in;

  assign raw_in = '{frame: frame_ref_in, sig_en: sig_en_in,
                    pwr: pwr_up_in, lpbk_n: lpbk_n_in};

  loopsup_sync #(.WIDTH($bits(ctl_in_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  loopsup_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .se_s       (syn_in.sig_en),
    .pwr_s      (syn_in.pwr),
    .lpbk_n_s   (syn_in.lpbk_n),
    .pwr_q      (pwr_latched),
    .lpbk_n_q   (lpbk_n_latched),
    .oe_q       (status_oe),
    .loop_sel_q (loop_sel)
  );

  loopsup_frame #(.MISS_LIMIT(MISS_LIMIT)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .frame_lvl  (syn_in.frame),
    .burst_ok   (burst_ok),
    .pwr_up     (pwr_latched),
    .valid_q    (valid_data),
    .timeout_q  (timeout),
    .tx_start_q (tx_start)
  );

  // R1: the block comes out of reset in time-out
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (timeout && !valid_data && !tx_start));
endmodule

// File: tb/loop_supervisor_tb.sv
module loop_supervisor_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_ref_in = 1'b0, burst_ok = 1'b0, pwr_up_in = 1'b0;
  logic lpbk_n_in = 1'b1, sig_en_in = 1'b1;
  logic valid_data, status_oe, pwr_latched, lpbk_n_latched;
  logic tx_start, loop_sel, timeout;

  int checks = 0, errors = 0, tx_seen = 0;
  int m_cnt = 3, m_tx = 0;
  bit m_tout = 1, m_vd = 0, m_pwr = 0, m_lbn = 1, done = 0;

  always #5 clk = ~clk;

  loop_supervisor u_dut (
    .clk(clk), .rst(rst), .frame_ref_in(frame_ref_in), .burst_ok(burst_ok),
    .pwr_up_in(pwr_up_in), .lpbk_n_in(lpbk_n_in), .sig_en_in(sig_en_in),
    .valid_data(valid_data), .status_oe(status_oe), .pwr_latched(pwr_latched),
    .lpbk_n_latched(lpbk_n_latched), .tx_start(tx_start), .loop_sel(loop_sel),
    .timeout(timeout)
  );

  always @(negedge clk) if (!rst && tx_start) tx_seen++;

  function automatic int miss_after_frame(int c);
    return (c >= 3) ? 3 : c + 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all();
    chk("R2/R3 valid_data", valid_data, m_vd);
    chk("R4/R5 timeout", timeout, m_tout);
    chk("R7 tx_start count", tx_seen, m_tx);
    chk("R8 pwr_latched", pwr_latched, m_pwr);
    chk("R8 lpbk_n_latched", lpbk_n_latched, m_lbn);
    chk("R10 loop_sel", loop_sel, (m_pwr && !m_lbn) ? 1 : 0);
  endtask

  task automatic do_frame();
    @(negedge clk) frame_ref_in = 1'b1;
    wait_n(3);
    frame_ref_in = 1'b0;
    wait_n(4);
    m_cnt = miss_after_frame(m_cnt);
    m_tout = (m_cnt == 3);
    m_vd = (m_cnt != 3);
    if (m_pwr) m_tx++;
  endtask

  task automatic do_burst();
    @(negedge clk) burst_ok = 1'b1;
    @(negedge clk) burst_ok = 1'b0;
    m_cnt = 0;
    if (!m_pwr) m_vd = 1;
    wait_n(2);
  endtask

  task automatic set_ctl(bit p, bit l);
    @(negedge clk);
    pwr_up_in = p;
    lpbk_n_in = l;
    wait_n(5);
    m_pwr = p;
    m_lbn = l;
  endtask

  task automatic se_window(bit p, bit l);
    @(negedge clk) sig_en_in = 1'b0;
    wait_n(5);
    chk("R9 oe low", status_oe, 0);
    pwr_up_in = p;
    lpbk_n_in = l;
    wait_n(5);
    chk("R8 frozen pwr", pwr_latched, m_pwr);
    chk("R8 frozen lpbk", lpbk_n_latched, m_lbn);
    sig_en_in = 1'b1;
    wait_n(5);
    m_pwr = p;
    m_lbn = l;
    chk("R9 oe high", status_oe, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_n(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 timeout", timeout, 1);
    chk("R1 valid_data", valid_data, 0);
    chk("R1 tx_start", tx_start, 0);
    chk("R1 status_oe", status_oe, 0);
    chk("R1 pwr_latched", pwr_latched, 0);
    chk("R1 lpbk_n_latched", lpbk_n_latched, 1);
    wait_n(5);
    chk("R9 oe follows enable", status_oe, 1);

    // R3/R5: powered down, burst in time-out
    do_burst();
    chk("R3 vd rises on burst", valid_data, 1);
    chk("R5 timeout held until edge", timeout, 1);
    do_frame();
    chk("R5 timeout cleared at edge", timeout, 0);
    do_frame();
    chk("R3 vd holds after 2 edges", valid_data, 1);
    chk("R4 no timeout after 2 edges", timeout, 0);
    do_frame();
    chk("R4 timeout at third edge", timeout, 1);
    chk("R6 vd low in timeout", valid_data, 0);
    for (int i = 0; i < 6; i++) do_frame();
    chk("R4 saturated timeout", timeout, 1);
    chk("R7 no tx while down", tx_seen, 0);

    // R2: powered up, burst waits for the frame edge
    set_ctl(1'b1, 1'b1);
    do_burst();
    chk("R2 vd held between edges", valid_data, 0);
    do_frame();
    chk("R2 vd at edge", valid_data, 1);
    chk("R7 one tx pulse", tx_seen, 1);
    set_ctl(1'b1, 1'b0);
    chk("R10 loop active", loop_sel, 1);
    set_ctl(1'b0, 1'b0);
    chk("R10 loop off when down", loop_sel, 0);
    se_window(1'b1, 1'b1);
    check_all();

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0, 1, 2: do_frame();
        3, 4:    do_burst();
        5:       set_ctl(~m_pwr, m_lbn);
        6:       set_ctl(m_pwr, ~m_lbn);
        default: se_window(bit'($urandom % 2), bit'($urandom % 2));
      endcase
      check_all();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule